// File: doc/BRIEF.md
# Serial Avionics Word Receiver

This block turns one return-to-zero avionics serial channel into parallel words. It takes the two logic-level legs of the line after analog translation, classifies each sample as one, zero or null, and recovers bits by oversampling at ten samples per bit. A configuration input sets the sample rate to the system clock divided by 10 or by 80. Bits are framed into 32-bit or 25-bit words. An incomplete word is dropped when the line stays null for too long in the middle of the word.

Each complete word passes an optional two-bit source/destination filter on word bits 9 and 10. A word that passes is loaded into a holding register, together with a parity status bit, and a ready flag is set. A host reads the word as two 16-bit halves. It chooses the half with a select input and pulses a read strobe. Reading the second half clears the ready flag. For self-test, the block can take a loopback pair of legs from a local transmitter instead of the line. A parameter swaps that pair so that the instance receives the inverted stream.

Top module: `a429_word_receiver`

## Requirements
- R1: Samples are taken once every 10 clocks when `cfg_slow_rate` is 0 and once every 80 clocks when it is 1. A bit lasts ten samples: five driven and five null.
- R2: A word is 32 bits when `cfg_short_word` is 0 and 25 bits when it is 1. The first bit received is word bit 1.
- R3: If the line stays null for more than two bit times after at least one bit of a word has arrived, the partial word is discarded. Nothing is latched and the ready flag does not change.
- R4: A word that passes the filter is loaded into the holding register, and `word_ready` goes to 1 on the next clock. If the word is not read, the next accepted word overwrites it.
- R5: When `cfg_match_en` is 1 in 32-bit mode, a word is kept only if word bit 9 equals `cfg_match_x` and word bit 10 equals `cfg_match_y`. Otherwise it is dropped and the held word does not change. With `cfg_match_en` at 0, or in 25-bit mode, every word is kept.
- R6: The parity status, output on bit 8 of the first half, is 1 when the received word (including its parity bit) holds an even number of ones and 0 when it holds an odd number.
- R7: `rd_data` is 0 whenever `rd_strobe` is low. A strobe with `rd_half`=0 drives the first half and leaves `word_ready` unchanged. A strobe with `rd_half`=1 drives the second half and clears `word_ready` at the next clock. Reads may be repeated in any order.
- R8: First half in 32-bit mode: bits 7..0 = word bits 1..8, with bit 7 holding word bit 1; bit 8 = parity status; bits 10,9 = word bits 31,30; bits 12,11 = word bits 10,9; bit 13 = word bit 11; bits 15,14 = word bits 13,12. Second half: bit k = word bit 14+k, for k from 0 to 15.
- R9: First half in 25-bit mode: the label as in R8, parity status on bit 8, and bits 15..9 read as 0. Second half: bit k = word bit 9+k, for k from 0 to 15.
- R10: With `cfg_selftest_n` at 0, the receiver decodes `loop_hi`/`loop_lo` and ignores `line_hi`/`line_lo`. With `LOOP_SWAP`=1, the loop legs are exchanged.
- R11: A sample with high leg 1 and low leg 0 is a one, the reverse is a zero, and any other sample is null. A bit is taken once three consecutive equal non-null samples follow a null.
- R12: While `rst_n` is low, the bit counter, the partial word, the holding register and `word_ready` are cleared. Both halves then read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset |
| line_hi | input | 1 | Line high leg, logic level |
| line_lo | input | 1 | Line low leg, logic level |
| loop_hi | input | 1 | Self-test loopback high leg |
| loop_lo | input | 1 | Self-test loopback low leg |
| cfg_selftest_n | input | 1 | 0 selects the loopback legs |
| cfg_slow_rate | input | 1 | 0: sample every 10 clocks; 1: every 80 clocks |
| cfg_short_word | input | 1 | 0: 32-bit words; 1: 25-bit words |
| cfg_match_en | input | 1 | Enables the source/destination filter |
| cfg_match_x | input | 1 | Value required on word bit 9 |
| cfg_match_y | input | 1 | Value required on word bit 10 |
| rd_half | input | 1 | 0 selects the first half, 1 the second |
| rd_strobe | input | 1 | Read strobe, one clock per read |
| rd_data | output | 16 | Selected half while strobed, else 0 |
| word_ready | output | 1 | A kept word is waiting |

## Verification
On every cycle, the assertions check the following: sample ticks never come back to back; bits are taken only on a sample tick; the bit counter stays inside a word; an abort is never followed by a completion; an accepted word raises the ready flag and a dropped word leaves the holding register unchanged; a first-half read keeps the flag and a second-half read clears it. Only the bench scenarios can show the rest. These are the shuffled bit placement of each half in both word lengths, the parity status value, the filter outcomes with match and mismatch, the discard of a broken word followed by a clean one, overwrite without a read, the divide-by-80 rate, and the loopback path that ignores the line.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

  localparam int WORD_LONG  = 32;
  localparam int WORD_SHORT = 25;
  localparam int HALF_W     = 16;

  typedef enum logic [1:0] {
    SYM_NULL = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_ZERO = 2'd2
  } line_sym_t;

  // Map the two leg levels to a line symbol.
  function automatic line_sym_t classify_legs(input logic hi, input logic lo);
    if (hi && !lo) return SYM_ONE;
    if (!hi && lo) return SYM_ZERO;
    return SYM_NULL;
  endfunction

  // 1 for an even count of ones over the active word length.
  function automatic logic parity_status(input logic [WORD_LONG-1:0] w, input logic short_fmt);
    logic [WORD_LONG-1:0] m;
    m = short_fmt ? (w & {{(WORD_LONG-WORD_SHORT){1'b0}}, {WORD_SHORT{1'b1}}}) : w;
    return ~(^m);
  endfunction

  // w[k-1] holds word bit k.
  function automatic logic [HALF_W-1:0] first_half(input logic [WORD_LONG-1:0] w,
                                                   input logic ps, input logic short_fmt);
    logic [HALF_W-1:0] h;
    h = '0;
    for (int j = 0; j < 8; j++) h[7-j] = w[j];
    h[8] = ps;
    if (!short_fmt) begin
      h[9]  = w[29];
      h[10] = w[30];
      h[11] = w[8];
      h[12] = w[9];
      h[13] = w[10];
      h[14] = w[11];
      h[15] = w[12];
    end
    return h;
  endfunction

  function automatic logic [HALF_W-1:0] second_half(input logic [WORD_LONG-1:0] w,
                                                    input logic short_fmt);
    return short_fmt ? w[23:8] : w[28:13];
  endfunction

endpackage

// File: rtl/a429_rate_tick.sv
module a429_rate_tick #(
  parameter int FAST_DIV    = 10,
  parameter int SLOW_FACTOR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_sel,
  output logic sample_tick
);
  localparam int MAX_DIV = FAST_DIV * SLOW_FACTOR;
  localparam int CW      = $clog2(MAX_DIV);

  logic [CW-1:0] div_cnt;
  logic [CW-1:0] div_limit;

  assign div_limit = slow_sel ? CW'(MAX_DIV - 1) : CW'(FAST_DIV - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt     <= '0;
      sample_tick <= 1'b0;
    end else begin
      sample_tick <= 1'b0;
      if (div_cnt >= div_limit) begin
        div_cnt     <= '0;
        sample_tick <= 1'b1;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  AST_TICK_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);  // R1

endmodule

// File: rtl/a429_bit_slicer.sv
module a429_bit_slicer
  import a429_rx_pkg::*;
#(
  parameter int OVERSAMPLE     = 10,
  parameter int MAJORITY       = 3,
  parameter int GAP_LIMIT_BITS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_tick,
  input  logic leg_hi,
  input  logic leg_lo,
  output logic bit_valid,
  output logic bit_value,
  output logic null_long
);
  localparam int GAP_SAMPLES = OVERSAMPLE * GAP_LIMIT_BITS;
  localparam int NW          = $clog2(GAP_SAMPLES + 2);
  localparam int RW          = $clog2(OVERSAMPLE + 1);

  line_sym_t     sym_now;
  line_sym_t     sym_prev;
  logic [RW-1:0] run_len;
  logic [RW-1:0] run_next;
  logic          armed;
  logic [NW-1:0] null_run;

  assign sym_now = classify_legs(leg_hi, leg_lo);

  always_comb begin
    if (sym_now == sym_prev)
      run_next = (run_len == RW'(OVERSAMPLE)) ? run_len : run_len + 1'b1;
    else
      run_next = RW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_prev  <= SYM_NULL;
      run_len   <= '0;
      armed     <= 1'b1;
      null_run  <= '0;
      bit_valid <= 1'b0;
      bit_value <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      if (sample_tick) begin
        sym_prev <= sym_now;
        if (sym_now == SYM_NULL) begin
          run_len <= '0;
          armed   <= 1'b1;
          if (null_run != NW'(GAP_SAMPLES + 1)) null_run <= null_run + 1'b1;
        end else begin
          null_run <= '0;
          run_len  <= run_next;
          if (armed && run_next == RW'(MAJORITY)) begin
            bit_valid <= 1'b1;
            bit_value <= (sym_now == SYM_ONE);
            armed     <= 1'b0;
          end
        end
      end
    end
  end

  assign null_long = (null_run > NW'(GAP_SAMPLES));

  AST_BIT_ONLY_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(sample_tick));  // R11

endmodule

// File: rtl/a429_word_framer.sv
module a429_word_framer
  import a429_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 short_fmt,
  input  logic                 bit_valid,
  input  logic                 bit_value,
  input  logic                 null_long,
  output logic                 word_done,
  output logic [WORD_LONG-1:0] word_bits,
  output logic                 abort_evt
);
  localparam int CNTW = $clog2(WORD_LONG + 1);

  logic [CNTW-1:0] bit_cnt;
  logic [CNTW-1:0] word_len;
  logic [CNTW-1:0] cnt_inc;

  assign word_len  = short_fmt ? CNTW'(WORD_SHORT) : CNTW'(WORD_LONG);
  assign cnt_inc   = bit_cnt + 1'b1;
  assign abort_evt = null_long && (bit_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      word_bits <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (abort_evt) begin
        bit_cnt   <= '0;
        word_bits <= '0;
      end else if (bit_valid) begin
        word_bits[bit_cnt[CNTW-2:0]] <= bit_value;
        if (cnt_inc >= word_len) begin
          bit_cnt   <= '0;
          word_done <= 1'b1;
        end else begin
          bit_cnt <= cnt_inc;
        end
      end
    end
  end

  AST_COUNT_INSIDE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CNTW'(WORD_LONG));  // R2
  AST_ABORT_NO_COMPLETION: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !word_done);  // R3

endmodule

// File: rtl/a429_word_receiver.sv
module a429_word_receiver
  import a429_rx_pkg::*;
#(
  parameter int FAST_DIV       = 10,
  parameter int SLOW_FACTOR    = 8,
  parameter int OVERSAMPLE     = 10,
  parameter int MAJORITY       = 3,
  parameter int GAP_LIMIT_BITS = 2,
  parameter bit LOOP_SWAP      = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_hi,
  input  logic        line_lo,
  input  logic        loop_hi,
  input  logic        loop_lo,
  input  logic        cfg_selftest_n,
  input  logic        cfg_slow_rate,
  input  logic        cfg_short_word,
  input  logic        cfg_match_en,
  input  logic        cfg_match_x,
  input  logic        cfg_match_y,
  input  logic        rd_half,
  input  logic        rd_strobe,
  output logic [15:0] rd_data,
  output logic        word_ready
);
  logic                 sample_tick;
  logic                 lp_hi, lp_lo;
  logic                 rx_hi, rx_lo;
  logic                 bit_valid, bit_value, null_long;
  logic                 word_done, abort_evt;
  logic [WORD_LONG-1:0] word_bits;
  logic                 match_ok, accept_evt, drop_evt, clear_evt;
  logic [WORD_LONG-1:0] hold_bits;
  logic                 hold_ps, hold_short;

  generate
    if (LOOP_SWAP) begin : g_loop_inv
      assign lp_hi = loop_lo;
      assign lp_lo = loop_hi;
    end else begin : g_loop_true
      assign lp_hi = loop_hi;
      assign lp_lo = loop_lo;
    end
  endgenerate

  assign rx_hi = cfg_selftest_n ? line_hi : lp_hi;
  assign rx_lo = cfg_selftest_n ? line_lo : lp_lo;

  a429_rate_tick #(.FAST_DIV(FAST_DIV), .SLOW_FACTOR(SLOW_FACTOR)) i_tick (
    .clk(clk), .rst_n(rst_n), .slow_sel(cfg_slow_rate), .sample_tick(sample_tick));

  a429_bit_slicer #(.OVERSAMPLE(OVERSAMPLE), .MAJORITY(MAJORITY),
                    .GAP_LIMIT_BITS(GAP_LIMIT_BITS)) i_slicer (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .leg_hi(rx_hi), .leg_lo(rx_lo),
    .bit_valid(bit_valid), .bit_value(bit_value), .null_long(null_long));

  a429_word_framer i_framer (
    .clk(clk), .rst_n(rst_n), .short_fmt(cfg_short_word), .bit_valid(bit_valid),
    .bit_value(bit_value), .null_long(null_long), .word_done(word_done),
    .word_bits(word_bits), .abort_evt(abort_evt));

  // Named events for the checks below.
  assign match_ok   = (word_bits[8] == cfg_match_x) && (word_bits[9] == cfg_match_y);
  assign accept_evt = word_done && (cfg_short_word || !cfg_match_en || match_ok);
  assign drop_evt   = word_done && !accept_evt;
  assign clear_evt  = rd_strobe && rd_half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_bits  <= '0;
      hold_ps    <= 1'b0;
      hold_short <= 1'b0;
      word_ready <= 1'b0;
    end else begin
      if (accept_evt) begin
        hold_bits  <= word_bits;
        hold_ps    <= parity_status(word_bits, cfg_short_word);
        hold_short <= cfg_short_word;
        word_ready <= 1'b1;
      end else if (clear_evt) begin
        word_ready <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!rd_strobe)  rd_data = '0;
    else if (rd_half) rd_data = second_half(hold_bits, hold_short);
    else              rd_data = first_half(hold_bits, hold_ps, hold_short);
  end

  AST_ACCEPT_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> word_ready);  // R4
  AST_READY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_ready) |-> $past(accept_evt));  // R4
  AST_DROP_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> $stable(hold_bits));  // R5
  AST_SECOND_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_evt && !accept_evt) |=> !word_ready);  // R7
  AST_FIRST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rd_half && word_ready) |=> word_ready);  // R7

endmodule

// File: tb/test_a429_word_receiver.sv
`timescale 1ns/1ps
module test_a429_word_receiver;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic line_hi = 0, line_lo = 0, loop_hi = 0, loop_lo = 0;
  logic cfg_selftest_n = 1, cfg_slow_rate = 0, cfg_short_word = 0;
  logic cfg_match_en = 0, cfg_match_x = 0, cfg_match_y = 0;
  logic rd_half = 0, rd_strobe = 0;
  logic [15:0] rd_data;
  logic word_ready;

  a429_word_receiver i_a429_word_receiver (
    .clk(clk), .rst_n(rst_n), .line_hi(line_hi), .line_lo(line_lo),
    .loop_hi(loop_hi), .loop_lo(loop_lo), .cfg_selftest_n(cfg_selftest_n),
    .cfg_slow_rate(cfg_slow_rate), .cfg_short_word(cfg_short_word),
    .cfg_match_en(cfg_match_en), .cfg_match_x(cfg_match_x), .cfg_match_y(cfg_match_y),
    .rd_half(rd_half), .rd_strobe(rd_strobe), .rd_data(rd_data), .word_ready(word_ready));

  int checks = 0;
  int errors = 0;
  int sp = 10;          // clocks per sample
  bit use_loop = 0;
  bit auto_read = 0;
  logic [15:0] exp_a[$];
  logic [15:0] exp_b[$];
  string       exp_tag[$];

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected halves, built from the requirement text.
  function automatic logic [15:0] exp_first(logic [31:0] w, int n);
    logic [15:0] h;
    int ones;
    h = 16'h0;
    ones = 0;
    for (int i = 0; i < n; i++) ones += w[i];
    for (int k = 0; k < 8; k++) h[k] = w[7-k];
    h[8] = (ones % 2 == 0);
    if (n == 32) begin
      h[15:14] = {w[12], w[11]};
      h[13]    = w[10];
      h[12:11] = {w[9], w[8]};
      h[10:9]  = {w[30], w[29]};
    end
    return h;
  endfunction

  function automatic logic [15:0] exp_second(logic [31:0] w, int n);
    logic [15:0] h;
    for (int k = 0; k < 16; k++) h[k] = (n == 32) ? w[13+k] : w[8+k];
    return h;
  endfunction

  task automatic drive_legs(logic h, logic l, int samples);
    if (use_loop) begin
      loop_hi = h; loop_lo = l; line_hi = l; line_lo = h;
    end else begin
      line_hi = h; line_lo = l; loop_hi = 0; loop_lo = 0;
    end
    repeat (samples * sp) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] w, int n);
    for (int i = 0; i < n; i++) begin
      drive_legs(w[i], !w[i], 5);
      drive_legs(1'b0, 1'b0, 5);
    end
  endtask

  task automatic send_word(logic [31:0] w, int n, bit keep, string tag);
    if (keep) begin
      exp_a.push_back(exp_first(w, n));
      exp_b.push_back(exp_second(w, n));
      exp_tag.push_back(tag);
    end
    send_bits(w, n);
    drive_legs(1'b0, 1'b0, 40);
  endtask

  task automatic read_half(logic h, output logic [15:0] d);
    rd_half = h;
    rd_strobe = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 4000 && exp_a.size() != 0; i++) @(negedge clk);
    check("R4", "words left unread", exp_a.size(), 0);
  endtask

  // Monitor: pops the scoreboard whenever a word is flagged.
  initial begin
    logic [15:0] da, db, ea, eb;
    string t;
    forever begin
      @(negedge clk);
      if (auto_read && word_ready) begin
        if (exp_a.size() == 0) begin
          check("R5", "unexpected ready", 1, 0);
          read_half(1'b1, db);
        end else begin
          ea = exp_a.pop_front();
          eb = exp_b.pop_front();
          t  = exp_tag.pop_front();
          read_half(1'b0, da);
          check(t, "first half", da, ea);
          read_half(1'b1, db);
          check(t, "second half", db, eb);
          check("R7", "ready after second half", word_ready, 0);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12", "ready after reset", word_ready, 0);
    check("R7", "bus idle", rd_data, 0);
    read_half(1'b0, d); check("R12", "first half after reset", d, 0);
    read_half(1'b1, d); check("R12", "second half after reset", d, 0);

    // R8 / R6 / R11: 32-bit words, both parities
    auto_read = 1;
    send_word(32'h0000_0003, 32, 1, "R6");
    send_word(32'h0000_0001, 32, 1, "R6");
    send_word(32'hA5C3_0F17, 32, 1, "R8");
    send_word(32'h5E71_9B2C, 32, 1, "R11");
    drain();

    // R5 filter: keep on match, drop on mismatch
    cfg_match_en = 1; cfg_match_x = 1; cfg_match_y = 0;
    send_word(32'h6B2D_41C5, 32, 1, "R5");
    drain();
    send_word(32'h6B2D_40C5, 32, 0, "R5");
    check("R5", "ready after dropped word", word_ready, 0);
    read_half(1'b0, d); check("R5", "held word after drop", d, exp_first(32'h6B2D_41C5, 32));

    // R9 / R2: 25-bit words bypass the filter
    cfg_short_word = 1;
    send_word(32'h0012_3C5A, 25, 1, "R9");
    send_word(32'h01F0_0E81, 25, 1, "R2");
    drain();

    // R3 broken word then a clean one
    cfg_match_en = 0; cfg_short_word = 0;
    send_bits(32'hFFFF_FFFF, 12);
    drive_legs(1'b0, 1'b0, 300);
    check("R3", "ready after broken word", word_ready, 0);
    send_word(32'h1357_9BDF, 32, 1, "R3");
    drain();

    // R4 overwrite and R7 read semantics
    auto_read = 0;
    send_word(32'hDEAD_BEEF, 32, 0, "R4");
    send_word(32'h0F0F_3355, 32, 0, "R4");
    check("R4", "ready after two words", word_ready, 1);
    check("R7", "bus idle while ready", rd_data, 0);
    read_half(1'b1, d); check("R4", "second half overwritten", d, exp_second(32'h0F0F_3355, 32));
    check("R7", "ready after second half", word_ready, 0);
    read_half(1'b0, d); check("R4", "first half overwritten", d, exp_first(32'h0F0F_3355, 32));
    check("R7", "ready stays low after first half", word_ready, 0);
    send_word(32'h2468_ACE0, 32, 0, "R7");
    read_half(1'b0, d); check("R7", "first half", d, exp_first(32'h2468_ACE0, 32));
    check("R7", "ready kept by first half", word_ready, 1);
    read_half(1'b0, d); check("R7", "repeated first half", d, exp_first(32'h2468_ACE0, 32));
    read_half(1'b1, d); check("R7", "second half", d, exp_second(32'h2468_ACE0, 32));
    check("R7", "ready cleared", word_ready, 0);

    // R10 self-test loop, line legs carry the complement
    auto_read = 1;
    cfg_selftest_n = 0; use_loop = 1;
    send_word(32'h7A0C_93E1, 32, 1, "R10");
    drain();
    cfg_selftest_n = 1; use_loop = 0;

    // R1 slow rate, 25-bit word
    cfg_slow_rate = 1; sp = 80; cfg_short_word = 1;
    send_word(32'h00AB_CD12, 25, 1, "R1");
    drain();
    cfg_slow_rate = 0; sp = 10; cfg_short_word = 0;
    drive_legs(1'b0, 1'b0, 20);

    // R12 reset clears a waiting word
    auto_read = 0;
    send_word(32'h1111_2222, 32, 0, "R12");
    check("R12", "ready before reset", word_ready, 1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", "ready after reset", word_ready, 0);
    read_half(1'b0, d); check("R12", "first half cleared", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule